// File: doc/BRIEF.md
# GPIO Interrupt Router with Per-CPU Views

This block sits between a 32-line GPIO bank and up to four processors. It takes the bank's input levels, already corrected for polarity, and one-cycle edge event pulses per line. It turns them into grouped interrupt requests. Each processor sees its own copy of the interrupt state. The cause presented to a view is the input level gated by that view's level mask, ORed with the view's latched edge cause gated by its edge mask. Each run of eight lines folds into one request output, so every view drives four requests.

A global view is always present. Its edge cause sits at 0x14, its edge mask at 0x18 and its level mask at 0x1C. The `MODE` parameter, fixed at elaboration, picks how processor views are built. Single mode has no processor views. Shared mode gives two processors one common edge cause with separate masks. Per-CPU mode gives four processors a private cause and private masks each, placed in a second register window. Software programs the block through a simple write port and reads it back through a read port with one cycle of latency. An edge cause copy is acknowledged by a write in which 0 bits clear and 1 bits keep.

Top module: `gpio_irq_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all four `irq_glb` bits, all sixteen `irq_cpu` bits and `reg_rdata` are 0. Every cause and mask register then reads back as 0.
- R2: One cycle after its inputs, each request output equals the OR over eight lines of (data_in AND level mask) OR (edge cause AND edge mask). Request bit g covers lines 8g to 8g+7.
- R3: An `edge_evt` bit sets the matching bit in the global edge cause and in every per-CPU edge cause copy on the next cycle.
- R4: A write to a cause address ANDs that copy with `reg_wdata`, so 0 clears and 1 keeps. No other copy changes.
- R5: When an edge event and an acknowledge that would clear the same bit land in one cycle, the bit ends up set.
- R6: In per-CPU mode (`MODE`=2), with `reg_win`=1, CPU n's edge cause is at n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4. It drives `irq_cpu[4n+3:4n]`.
- R7: With `reg_win`=0, edge cause 0x14, edge mask 0x18 and level mask 0x1C form the global view on `irq_glb` in every mode.
- R8: In shared mode (`MODE`=1), CPU0 uses the global cause and masks. CPU1 uses the global cause with its edge mask at 0x30 and its level mask at 0x34 (`reg_win`=0). CPU2 and CPU3 requests stay 0.
- R9: In single mode (`MODE`=0), `irq_cpu` stays 0. Writes to the per-CPU window and to 0x30/0x34 have no effect and read back 0.
- R10: `reg_rdata` shows, one cycle later, the register selected by `reg_win`/`reg_addr` as it was before that cycle's write. Unmapped addresses read 0.
- R11: A write to a mask address loads the whole 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 1 | Window select: 0 main, 1 per-CPU |
| reg_addr | input | 8 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| data_in | input | 32 | Polarity-corrected line levels |
| edge_evt | input | 32 | One-cycle edge event pulses per line |
| irq_glb | output | 4 | Global view group requests |
| irq_cpu | output | 16 | Per-processor group requests, four per CPU |

## Verification
The assertions assume that `edge_evt` and the write port are the only agents that change the global cause. They also assume that the block leaves `rst` through a real reset cycle. The stimulus drives every input at the falling edge. It raises events and acknowledges only as single-cycle strobes. It always starts with several reset cycles. All three modes are instantiated side by side and receive identical stimulus. The bench can therefore confirm that single mode ignores the per-CPU window and the shared-mode addresses under the same writes that program the other two builds.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  typedef enum int {
    MODE_SINGLE = 0,
    MODE_SHARED = 1,
    MODE_PERCPU = 2
  } irqr_mode_e;

  // main window
  localparam logic [7:0] OFS_GCAUSE  = 8'h14;
  localparam logic [7:0] OFS_GEMASK  = 8'h18;
  localparam logic [7:0] OFS_GLMASK  = 8'h1C;
  localparam logic [7:0] OFS_C1EMASK = 8'h30;
  localparam logic [7:0] OFS_C1LMASK = 8'h34;
  // per-CPU window
  localparam logic [7:0] OFS_PC_EMASK = 8'h10;
  localparam logic [7:0] OFS_PC_LMASK = 8'h20;
  localparam int         PC_STRIDE    = 4;
endpackage

// File: rtl/irqr_cause.sv
module irqr_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_we,
  input  logic [W-1:0] keep,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic [W-1:0] kept;
  assign kept = ack_we ? (q & keep) : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= kept | set;  // set applied last: set beats clear
  end
endmodule

// File: rtl/irqr_mask.sv
module irqr_mask #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/irqr_view.sv
module irqr_view #(
  parameter int NL  = 32,
  parameter int GRP = 8,
  localparam int NG = NL / GRP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] data_in,
  input  logic [NL-1:0] cause,
  input  logic [NL-1:0] emask,
  input  logic [NL-1:0] lmask,
  output logic [NG-1:0] irq_o
);
  logic [NL-1:0] hit;
  assign hit = (data_in & lmask) | (cause & emask);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else begin
      for (int g = 0; g < NG; g++) irq_o[g] <= |hit[g*GRP +: GRP];
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import irqr_pkg::*;
#(
  parameter int MODE      = MODE_PERCPU,
  parameter int NL        = 32,
  parameter int GRP       = 8,
  parameter int CPU_SLOTS = 4,
  parameter int AW        = 8,
  localparam int NG       = NL / GRP
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic                    reg_win,
  input  logic [AW-1:0]           reg_addr,
  input  logic [NL-1:0]           reg_wdata,
  output logic [NL-1:0]           reg_rdata,
  input  logic [NL-1:0]           data_in,
  input  logic [NL-1:0]           edge_evt,
  output logic [NG-1:0]           irq_glb,
  output logic [CPU_SLOTS*NG-1:0] irq_cpu
);
  logic main_we, pc_we;
  assign main_we = reg_we && !reg_win;
  assign pc_we   = reg_we && reg_win && (MODE == MODE_PERCPU);

  // global view registers
  logic [NL-1:0] gcause_q, gemask_q, glmask_q;

  irqr_cause #(.W(NL)) u_gcause (
    .clk(clk), .rst(rst),
    .ack_we(main_we && reg_addr == AW'(OFS_GCAUSE)),
    .keep(reg_wdata), .set(edge_evt), .q(gcause_q));

  irqr_mask #(.W(NL)) u_gemask (
    .clk(clk), .rst(rst),
    .we(main_we && reg_addr == AW'(OFS_GEMASK)),
    .d(reg_wdata), .q(gemask_q));

  irqr_mask #(.W(NL)) u_glmask (
    .clk(clk), .rst(rst),
    .we(main_we && reg_addr == AW'(OFS_GLMASK)),
    .d(reg_wdata), .q(glmask_q));

  irqr_view #(.NL(NL), .GRP(GRP)) u_gview (
    .clk(clk), .rst(rst), .data_in(data_in),
    .cause(gcause_q), .emask(gemask_q), .lmask(glmask_q),
    .irq_o(irq_glb));

  // second processor masks, shared mode only
  logic [NL-1:0] c1_em, c1_lm;

  if (MODE == MODE_SHARED) begin : g_c1
    irqr_mask #(.W(NL)) u_em (
      .clk(clk), .rst(rst),
      .we(main_we && reg_addr == AW'(OFS_C1EMASK)),
      .d(reg_wdata), .q(c1_em));
    irqr_mask #(.W(NL)) u_lm (
      .clk(clk), .rst(rst),
      .we(main_we && reg_addr == AW'(OFS_C1LMASK)),
      .d(reg_wdata), .q(c1_lm));
  end else begin : g_no_c1
    assign c1_em = '0;
    assign c1_lm = '0;
  end

  // per-processor storage and views
  logic [NL-1:0] pc_cause [CPU_SLOTS];
  logic [NL-1:0] pc_em    [CPU_SLOTS];
  logic [NL-1:0] pc_lm    [CPU_SLOTS];
  logic [NL-1:0] vc       [CPU_SLOTS];
  logic [NL-1:0] vem      [CPU_SLOTS];
  logic [NL-1:0] vlm      [CPU_SLOTS];

  for (genvar n = 0; n < CPU_SLOTS; n++) begin : g_cpu
    if (MODE == MODE_PERCPU) begin : g_own
      irqr_cause #(.W(NL)) u_cause (
        .clk(clk), .rst(rst),
        .ack_we(pc_we && reg_addr == AW'(n*PC_STRIDE)),
        .keep(reg_wdata), .set(edge_evt), .q(pc_cause[n]));
      irqr_mask #(.W(NL)) u_em (
        .clk(clk), .rst(rst),
        .we(pc_we && reg_addr == AW'(OFS_PC_EMASK + n*PC_STRIDE)),
        .d(reg_wdata), .q(pc_em[n]));
      irqr_mask #(.W(NL)) u_lm (
        .clk(clk), .rst(rst),
        .we(pc_we && reg_addr == AW'(OFS_PC_LMASK + n*PC_STRIDE)),
        .d(reg_wdata), .q(pc_lm[n]));
      assign vc[n]  = pc_cause[n];
      assign vem[n] = pc_em[n];
      assign vlm[n] = pc_lm[n];
    end else if (MODE == MODE_SHARED && n < 2) begin : g_shr
      assign pc_cause[n] = '0;
      assign pc_em[n]    = '0;
      assign pc_lm[n]    = '0;
      assign vc[n]       = gcause_q;
      assign vem[n]      = (n == 0) ? gemask_q : c1_em;
      assign vlm[n]      = (n == 0) ? glmask_q : c1_lm;
    end else begin : g_off
      assign pc_cause[n] = '0;
      assign pc_em[n]    = '0;
      assign pc_lm[n]    = '0;
      assign vc[n]       = '0;
      assign vem[n]      = '0;
      assign vlm[n]      = '0;
    end

    irqr_view #(.NL(NL), .GRP(GRP)) u_view (
      .clk(clk), .rst(rst), .data_in(data_in),
      .cause(vc[n]), .emask(vem[n]), .lmask(vlm[n]),
      .irq_o(irq_cpu[n*NG +: NG]));
  end

  // registered read port
  logic [NL-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (!reg_win) begin
      if (reg_addr == AW'(OFS_GCAUSE))  rd_d = gcause_q;
      if (reg_addr == AW'(OFS_GEMASK))  rd_d = gemask_q;
      if (reg_addr == AW'(OFS_GLMASK))  rd_d = glmask_q;
      if (reg_addr == AW'(OFS_C1EMASK)) rd_d = c1_em;
      if (reg_addr == AW'(OFS_C1LMASK)) rd_d = c1_lm;
    end else begin
      for (int n = 0; n < CPU_SLOTS; n++) begin
        if (reg_addr == AW'(n*PC_STRIDE))                rd_d = pc_cause[n];
        if (reg_addr == AW'(OFS_PC_EMASK + n*PC_STRIDE)) rd_d = pc_em[n];
        if (reg_addr == AW'(OFS_PC_LMASK + n*PC_STRIDE)) rd_d = pc_lm[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irqr_pkg::*;
#(
  parameter int NL = 32,
  parameter int NG = 4,
  parameter int NC = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic          reg_win,
  input logic [AW-1:0] reg_addr,
  input logic [NL-1:0] data_in,
  input logic [NL-1:0] edge_evt,
  input logic [NL-1:0] gcause,
  input logic [NL-1:0] glmask,
  input logic [NG-1:0] irq_glb,
  input logic [NC-1:0] irq_cpu
);
  logic gack;
  assign gack = reg_we && !reg_win && reg_addr == AW'(OFS_GCAUSE);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_glb == '0 && irq_cpu == '0 && gcause == '0));

  assert_level_reaches_out_R2: assert property (@(posedge clk) disable iff (rst)
    (|(data_in & glmask)) |=> (irq_glb != '0));

  assert_event_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (|edge_evt) |=> ((gcause & $past(edge_evt)) == $past(edge_evt)));

  assert_cause_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!gack && edge_evt == '0) |=> $stable(gcause));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (gack && (|edge_evt)) |=> ((gcause & $past(edge_evt)) == $past(edge_evt)));
endmodule

bind gpio_irq_router irqr_checker #(
  .NL(NL), .NG(NG), .NC(CPU_SLOTS*NG), .AW(AW)
) u_irqr_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_win(reg_win),
  .reg_addr(reg_addr), .data_in(data_in), .edge_evt(edge_evt),
  .gcause(gcause_q), .glmask(glmask_q),
  .irq_glb(irq_glb), .irq_cpu(irq_cpu)
);

// File: tb/tb_gpio_irq_router.sv
`timescale 1ns/1ps
module tb_gpio_irq_router;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        we = 1'b0, win = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, din = '0, evt = '0;

  logic [31:0] rd_a  [3];
  logic [3:0]  glb_a [3];
  logic [15:0] cpu_a [3];

  gpio_irq_router #(.MODE(2)) dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_win(win), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_a[0]), .data_in(din), .edge_evt(evt),
    .irq_glb(glb_a[0]), .irq_cpu(cpu_a[0]));
  gpio_irq_router #(.MODE(1)) dut_sh (
    .clk(clk), .rst(rst), .reg_we(we), .reg_win(win), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_a[1]), .data_in(din), .edge_evt(evt),
    .irq_glb(glb_a[1]), .irq_cpu(cpu_a[1]));
  gpio_irq_router #(.MODE(0)) dut_sg (
    .clk(clk), .rst(rst), .reg_we(we), .reg_win(win), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_a[2]), .data_in(din), .edge_evt(evt),
    .irq_glb(glb_a[2]), .irq_cpu(cpu_a[2]));

  int md [3] = '{2, 1, 0};
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_gc [3], m_gem [3], m_glm [3], m_c1em [3], m_c1lm [3];
  logic [31:0] m_pc [3][4], m_pem [3][4], m_plm [3][4];

  function automatic logic [3:0] grp(input logic [31:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rd_model(input int k, input logic w, input logic [7:0] a);
    if (!w) begin
      case (a)
        8'h14: return m_gc[k];
        8'h18: return m_gem[k];
        8'h1C: return m_glm[k];
        8'h30: return (md[k] == 1) ? m_c1em[k] : 32'h0;
        8'h34: return (md[k] == 1) ? m_c1lm[k] : 32'h0;
        default: return 32'h0;
      endcase
    end
    if (md[k] != 2) return 32'h0;
    for (int n = 0; n < 4; n++) begin
      if (a == 8'(n*4))        return m_pc[k][n];
      if (a == 8'(16 + n*4))   return m_pem[k][n];
      if (a == 8'(32 + n*4))   return m_plm[k][n];
    end
    return 32'h0;
  endfunction

  task automatic check(input string tag, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode%0d %s actual=%h expected=%h", tag, md[k], what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w_e, input logic w_w,
                      input logic [7:0] a, input logic [31:0] wd,
                      input logic [31:0] d, input logic [31:0] ev, input string tag);
    logic [3:0]  eg [3];
    logic [15:0] ec [3];
    logic [31:0] er [3];
    rst = r; we = w_e; win = w_w; addr = a; wdata = wd; din = d; evt = ev;
    for (int k = 0; k < 3; k++) begin
      if (r) begin
        eg[k] = '0; ec[k] = '0; er[k] = '0;
        m_gc[k] = '0; m_gem[k] = '0; m_glm[k] = '0; m_c1em[k] = '0; m_c1lm[k] = '0;
        for (int n = 0; n < 4; n++) begin
          m_pc[k][n] = '0; m_pem[k][n] = '0; m_plm[k][n] = '0;
        end
      end else begin
        eg[k] = grp((d & m_glm[k]) | (m_gc[k] & m_gem[k]));
        ec[k] = '0;
        for (int n = 0; n < 4; n++) begin
          if (md[k] == 2)
            ec[k][n*4 +: 4] = grp((d & m_plm[k][n]) | (m_pc[k][n] & m_pem[k][n]));
          else if (md[k] == 1 && n == 0)
            ec[k][3:0] = eg[k];
          else if (md[k] == 1 && n == 1)
            ec[k][7:4] = grp((d & m_c1lm[k]) | (m_gc[k] & m_c1em[k]));
        end
        er[k] = rd_model(k, w_w, a);
        if (w_e && !w_w) begin
          if (a == 8'h14) m_gc[k] = m_gc[k] & wd;
          if (a == 8'h18) m_gem[k] = wd;
          if (a == 8'h1C) m_glm[k] = wd;
          if (a == 8'h30 && md[k] == 1) m_c1em[k] = wd;
          if (a == 8'h34 && md[k] == 1) m_c1lm[k] = wd;
        end
        if (w_e && w_w && md[k] == 2) begin
          for (int n = 0; n < 4; n++) begin
            if (a == 8'(n*4))      m_pc[k][n]  = m_pc[k][n] & wd;
            if (a == 8'(16 + n*4)) m_pem[k][n] = wd;
            if (a == 8'(32 + n*4)) m_plm[k][n] = wd;
          end
        end
        m_gc[k] = m_gc[k] | ev;
        if (md[k] == 2)
          for (int n = 0; n < 4; n++) m_pc[k][n] = m_pc[k][n] | ev;
      end
    end
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(tag, k, "irq_glb", {28'h0, glb_a[k]}, {28'h0, eg[k]});
      check(tag, k, "irq_cpu", {16'h0, cpu_a[k]}, {16'h0, ec[k]});
      check(tag, k, "reg_rdata", rd_a[k], er[k]);
    end
  endtask

  task automatic idle(input logic [31:0] d, input string tag);
    step(0, 0, 0, 8'h00, '0, d, '0, tag);
  endtask

  task automatic wr(input logic w_w, input logic [7:0] a, input logic [31:0] wd, input string tag);
    step(0, 1, w_w, a, wd, din, '0, tag);
  endtask

  task automatic rd(input logic w_w, input logic [7:0] a, input string tag);
    step(0, 0, w_w, a, '0, din, '0, tag);
    step(0, 0, 0, 8'h00, '0, din, '0, tag);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, '0, '0, '0, "R1");
    for (int a = 8'h14; a <= 8'h34; a += 4) rd(0, 8'(a), "R1");
    for (int a = 0; a <= 8'h2C; a += 4) rd(1, 8'(a), "R1");
    // R11 / R7: global masks
    wr(0, 8'h1C, 32'h0F0F_0000, "R11");
    wr(0, 8'h18, 32'h8000_0001, "R11");
    rd(0, 8'h1C, "R11");
    rd(0, 8'h18, "R7");
    // R2: level patterns hitting distinct groups
    idle(32'h0001_0000, "R2");
    idle(32'h0F00_0000, "R2");
    idle(32'h00FF_00FF, "R2");
    idle(32'h0101_0000, "R2");
    idle(32'h0, "R2");
    // R6: per-CPU window masks
    for (int n = 0; n < 4; n++) begin
      wr(1, 8'(32 + n*4), 32'h0000_00FF << (8*n), "R6");
      wr(1, 8'(16 + n*4), 32'h0000_0001 << (8*n + 1), "R6");
    end
    for (int n = 0; n < 4; n++) rd(1, 8'(32 + n*4), "R6");
    idle(32'hFFFF_FFFF, "R6");
    idle(32'h0000_FF00, "R6");
    idle(32'h0, "R6");
    // R3: edge events reach every copy
    step(0, 0, 0, 8'h00, '0, '0, 32'h0202_0203, "R3");
    idle(32'h0, "R3");
    rd(0, 8'h14, "R3");
    for (int n = 0; n < 4; n++) rd(1, 8'(n*4), "R3");
    // R4: acknowledge one copy only
    wr(1, 8'h04, 32'hFFFF_FDFF, "R4");
    rd(1, 8'h04, "R4");
    rd(1, 8'h00, "R4");
    wr(0, 8'h14, 32'hFFFF_FFFE, "R4");
    rd(0, 8'h14, "R4");
    idle(32'h0, "R4");
    // R5: set beats clear
    step(0, 1, 0, 8'h14, 32'h0, '0, 32'h0000_0004, "R5");
    rd(0, 8'h14, "R5");
    step(0, 1, 1, 8'h08, 32'h0, '0, 32'h0004_0000, "R5");
    rd(1, 8'h08, "R5");
    // R8: second processor masks in shared mode
    wr(0, 8'h30, 32'h0004_0000, "R8");
    wr(0, 8'h34, 32'h0000_0001, "R8");
    rd(0, 8'h30, "R8");
    rd(0, 8'h34, "R8");
    idle(32'h0000_0001, "R8");
    idle(32'h0, "R8");
    // R9: per-CPU window writes against the single build
    wr(1, 8'h2C, 32'hDEAD_BEEF, "R9");
    rd(1, 8'h2C, "R9");
    idle(32'hFF00_0000, "R9");
    // R10: unmapped addresses and read latency
    rd(0, 8'h40, "R10");
    rd(0, 8'h08, "R10");
    rd(1, 8'h3C, "R10");
    step(0, 1, 0, 8'h18, 32'h1234_5678, '0, '0, "R10");
    rd(0, 8'h18, "R10");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (R1..) actual=hung expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule